// File: doc/BRIEF.md
# Integer Decode-Execute Unit

This unit takes one 32-bit instruction word per clock, marked by a valid strobe. It splits the word into its fields and works out whether it is a register-register or a register-immediate operation. It then runs that operation in a small integer ALU against a private bank of 32 general registers, each 32 bits wide. The result is written into the destination register on the same rising edge that accepts the word. The supported operations are add, subtract, OR, signed compare, shift left and upper-immediate load.

A combinational debug port reads any register. Words outside the supported subset raise a one-cycle illegal pulse and change no register. That subset covers loads, stores, jumps and all other opcodes and function codes. Addition wraps silently.

Top module: `int_exec_unit`

## Requirements
- R1: After reset every register reads 0 on the debug port and `illegal_o` is low.
- R2: Register form (opcode bits 31:26 = 0) with funct bits 5:0 = 32 or 33 writes R[rd] = R[rs] + R[rt] modulo 2^32. The fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R3: Register form with funct 35 writes R[rd] = R[rs] - R[rt] modulo 2^32.
- R4: Register form with funct 37 writes R[rd] = R[rs] | R[rt].
- R5: Register form with funct 42 writes 1 to R[rd] when R[rs] < R[rt] as signed 32-bit values, and 0 otherwise.
- R6: Register form with funct 0 writes R[rd] = R[rt] shifted left by shamt (bits 10:6). The all-zero word changes nothing.
- R7: Opcode 8 writes R[rt] = R[rs] + sign-extended imm (bits 15:0), wrapping. Word 0x22D5FFCE subtracts 50 from R22 into R21.
- R8: Opcode 13 writes R[rt] = R[rs] | zero-extended imm.
- R9: Opcode 15 writes R[rt] = {imm, 16'h0000}.
- R10: Register 0 always reads 0; writes to it are discarded.
- R11: A valid word with any other opcode, or with opcode 0 and any other funct, sets `illegal_o` high for exactly the one cycle after the accepting edge and writes no register.
- R12: While `valid_i` is low the word is ignored: no register changes and `illegal_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| dbg_addr_i | input | 5 | Debug read register index |
| dbg_data_o | output | 32 | Debug read data, combinational |
| illegal_o | output | 1 | Unsupported word accepted last cycle |

## Verification
The bench goes after the edges of the arithmetic. A sign overflow at 0x7FFFFFFF + 1 shows whether a trap or a saturating adder was built by mistake. A signed compare of 0x80000000 against 1 gives the wrong bit if the comparison is done unsigned. The upper-immediate load must leave clean low bits, and the OR-immediate must zero-extend: a sign-extending one would set the upper half for immediates with bit 15 set. Every shift amount from 0 to 31 is swept, along with every opcode and every funct. The sweeps catch a decoder that quietly accepts a load or jump, or that writes a register on an illegal word. The bench also checks the illegal pulse for a second cycle that would appear if it were held. Writes aimed at register 0, and words presented with valid low, are checked for leaks into the bank.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned IMM_W   = 16;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_ORI  = 6'd13;
  localparam logic [5:0] OPC_LUI  = 6'd15;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_SLT  = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_OR,
    ALU_SLT,
    ALU_SLL,
    ALU_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e             op;
    logic                use_imm;
    logic                sext;
    logic                bad;
    logic [FIELD_W-1:0]  dst;
  } ctrl_t;

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              ctrl_o,
  output logic [FIELD_W-1:0] rs_o,
  output logic [FIELD_W-1:0] rt_o,
  output logic [FIELD_W-1:0] shamt_o,
  output logic [XLEN-1:0]    imm_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [5:0]         opc;
  logic [5:0]         fn;
  logic [FIELD_W-1:0] rd;
  logic [IMM_W-1:0]   imm;

  assign opc     = instr_i[31:26];
  assign rs_o    = instr_i[25:21];
  assign rt_o    = instr_i[20:16];
  assign rd      = instr_i[15:11];
  assign shamt_o = instr_i[10:6];
  assign fn      = instr_i[5:0];
  assign imm     = instr_i[15:0];

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.op      = ALU_ADD;
    ctrl_o.dst     = rt_o;
    ctrl_o.use_imm = 1'b1;
    unique case (opc)
      OPC_REG: begin
        ctrl_o.use_imm = 1'b0;
        ctrl_o.dst     = rd;
        case (fn)
          FN_ADD, FN_ADDU: ctrl_o.op = ALU_ADD;
          FN_SUBU:         ctrl_o.op = ALU_SUB;
          FN_OR:           ctrl_o.op = ALU_OR;
          FN_SLT:          ctrl_o.op = ALU_SLT;
          FN_SLL:          ctrl_o.op = ALU_SLL;
          default:         ctrl_o.bad = 1'b1;
        endcase
      end
      OPC_ADDI: begin
        ctrl_o.op   = ALU_ADD;
        ctrl_o.sext = 1'b1;
      end
      OPC_ORI: ctrl_o.op = ALU_OR;
      OPC_LUI: ctrl_o.op = ALU_LUI;
      default: ctrl_o.bad = 1'b1;
    endcase
  end

  assign imm_o = {{EXT_W{ctrl_o.sext & imm[IMM_W-1]}}, imm};

endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e            op_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [FIELD_W-1:0] shamt_i,
  output logic [XLEN-1:0]    y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_LUI: y_o = b_i << IMM_W;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/iexu_regfile.sv
module iexu_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   ra_addr_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [AW-1:0]   rb_addr_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic [AW-1:0]   rc_addr_i,
  output logic [XLEN-1:0] rc_data_o
);
  logic [XLEN-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_flop
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        q <= '0;
        else if (we_i && waddr_i == AW'(g)) q <= wdata_i;
      end
      assign bank[g] = q;
    end
  end

  assign ra_data_o = bank[ra_addr_i];
  assign rb_data_o = bank[rb_addr_i];
  assign rc_data_o = bank[rc_addr_i];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [AW-1:0]      dbg_addr_i,
  output logic [XLEN-1:0]    dbg_data_o,
  output logic               illegal_o
);
  ctrl_t              ctrl;
  logic [FIELD_W-1:0] rs, rt, shamt;
  logic [XLEN-1:0]    imm_ext, rs_val, rt_val, op_b, wr_data;
  logic               wr_en, illegal_q;

  iexu_decode #(.XLEN(XLEN)) u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .rs_o    (rs),
    .rt_o    (rt),
    .shamt_o (shamt),
    .imm_o   (imm_ext)
  );

  assign op_b = ctrl.use_imm ? imm_ext : rt_val;

  iexu_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (ctrl.op),
    .a_i     (rs_val),
    .b_i     (op_b),
    .shamt_i (shamt),
    .y_o     (wr_data)
  );

  assign wr_en = valid_i & ~ctrl.bad;

  iexu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .waddr_i   (AW'(ctrl.dst)),
    .wdata_i   (wr_data),
    .ra_addr_i (AW'(rs)),
    .ra_data_o (rs_val),
    .rb_addr_i (AW'(rt)),
    .rb_data_o (rt_val),
    .rc_addr_i (dbg_addr_i),
    .rc_data_o (dbg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= valid_i & ctrl.bad;
  end

  assign illegal_o = illegal_q;

endmodule

// File: rtl/iexu_checker.sv
module iexu_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic            illegal_o,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_data
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wr_en); // R12

  AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !illegal_o); // R12

  AST_WRITE_NOT_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !illegal_o); // R11

  AST_JUMP_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:26] == 6'd2) |=> illegal_o); // R11

  AST_UPPER_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && instr_i[31:26] == 6'd15) |-> wr_data[15:0] == 16'h0); // R9

  AST_COMPARE_IS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'd42)
      |-> wr_data[XLEN-1:1] == '0); // R5

endmodule

bind int_exec_unit iexu_checker #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .illegal_o (illegal_o),
  .wr_en     (wr_en),
  .wr_data   (wr_data)
);

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [4:0]  dbg_addr_i = '0;
  logic [31:0] dbg_data_o;
  logic        illegal_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] mrf [32];

  always #5 clk = ~clk;

  int_exec_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] itype(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  // Reference model built from the requirements; returns expected illegal flag
  function automatic bit model(logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    logic [31:0] a = mrf[w[25:21]];
    logic [31:0] b = mrf[w[20:16]];
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    logic [31:0] zx = {16'h0, w[15:0]};
    int d;
    logic [31:0] r;
    if (op == 0) begin
      d = int'(w[15:11]);
      if (fn == 32 || fn == 33) r = a + b;
      else if (fn == 35) r = a - b;
      else if (fn == 37) r = a | b;
      else if (fn == 42) r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      else if (fn == 0) r = b << w[10:6];
      else return 1'b1;
    end else begin
      d = int'(w[20:16]);
      if (op == 8) r = a + sx;
      else if (op == 13) r = a | zx;
      else if (op == 15) r = {w[15:0], 16'h0};
      else return 1'b1;
    end
    if (d != 0) mrf[d] = r;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(int r, output logic [31:0] v);
    dbg_addr_i = 5'(r);
    #1;
    v = dbg_data_o;
  endtask

  task automatic chk_reg(string req, int r);
    logic [31:0] v;
    rd_reg(r, v);
    chk(req, v, mrf[r]);
  endtask

  task automatic chk_all(string req);
    for (int r = 0; r < 32; r++) chk_reg(req, r);
  endtask

  // drive at negedge, sample one negedge after the accepting edge
  task automatic exec(logic [31:0] w, string req, bit check_dst);
    bit ill;
    @(negedge clk);
    valid_i = 1'b1;
    instr_i = w;
    ill = model(w);
    @(negedge clk);
    valid_i = 1'b0;
    chk({req, " flag"}, {31'b0, illegal_o}, {31'b0, ill});
    if (check_dst) chk_reg(req, (w[31:26] == 0) ? int'(w[15:11]) : int'(w[20:16]));
  endtask

  task automatic load(int r, logic [31:0] v);
    exec(itype(15, 0, r, v[31:16]), "R9", 1'b1);
    exec(itype(13, r, r, v[15:0]), "R8", 1'b1);
  endtask

  initial begin
    logic [31:0] vals [8];
    logic [31:0] v;
    vals = '{32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000001,
             32'h12345678, 32'hABABCDCD, 32'h00000000, 32'h00008000};
    for (int r = 0; r < 32; r++) mrf[r] = '0;
    #23 rst_ni = 1'b1;

    // R1 reset state
    chk_all("R1");
    chk("R1 flag", {31'b0, illegal_o}, 32'd0);

    for (int i = 0; i < 8; i++) load(i + 1, vals[i]);
    rd_reg(6, v);
    chk("R9 upper-load pattern", v, 32'hABABCDCD);

    // R8 zero extension with imm bit 15 set
    exec(itype(13, 0, 10, 16'h8001), "R8", 1'b1);
    rd_reg(10, v);
    chk("R8 zero-extend", v, 32'h00008001);

    // R7 worked example
    exec(itype(8, 0, 22, 16'd100), "R7", 1'b1);
    exec(32'h22D5FFCE, "R7", 1'b1);
    rd_reg(21, v);
    chk("R7 example", v, 32'd50);
    exec(itype(8, 3, 11, 16'h0001), "R7 wrap", 1'b1);
    rd_reg(11, v);
    chk("R7 wrap", v, 32'd0);

    // R2 overflow wraps
    exec(rtype(1, 4, 12, 0, 32), "R2", 1'b1);
    rd_reg(12, v);
    chk("R2 overflow wrap", v, 32'h80000000);
    // R5 signed compare
    exec(rtype(2, 4, 13, 0, 42), "R5", 1'b1);
    rd_reg(13, v);
    chk("R5 signed lt", v, 32'd1);
    exec(rtype(4, 2, 13, 0, 42), "R5", 1'b1);
    rd_reg(13, v);
    chk("R5 signed ge", v, 32'd0);

    // R2..R5 sweep over all operand pairs
    for (int a = 1; a <= 8; a++)
      for (int b = 1; b <= 8; b++) begin
        exec(rtype(a, b, 20, 0, 32), "R2 add", 1'b1);
        exec(rtype(a, b, 20, 0, 33), "R2 addu", 1'b1);
        exec(rtype(a, b, 20, 0, 35), "R3 subu", 1'b1);
        exec(rtype(a, b, 20, 0, 37), "R4 or", 1'b1);
        exec(rtype(a, b, 20, 0, 42), "R5 slt", 1'b1);
      end

    // R6 every shift amount
    for (int s = 0; s < 32; s++) exec(rtype(0, 5, 23, s, 0), "R6 sll", 1'b1);
    exec(32'h0, "R6 nop", 1'b0);
    chk_all("R6 nop");

    // R10 writes to register 0
    exec(itype(8, 1, 0, 16'h0005), "R10", 1'b0);
    exec(rtype(1, 2, 0, 0, 37), "R10", 1'b0);
    exec(itype(15, 0, 0, 16'hFFFF), "R10", 1'b0);
    rd_reg(0, v);
    chk("R10 zero", v, 32'd0);

    // R11 every opcode, then every funct
    for (int op = 1; op < 64; op++) begin
      exec(itype(op, 1, 24, 16'h1234), "R11 opcode", 1'b1);
      @(negedge clk);
      chk("R11 pulse", {31'b0, illegal_o}, 32'd0);
    end
    for (int fn = 0; fn < 64; fn++) begin
      exec(rtype(1, 2, 25, 3, fn), "R11 funct", 1'b1);
      @(negedge clk);
      chk("R11 pulse", {31'b0, illegal_o}, 32'd0);
    end
    chk_all("R11");

    // R12 word with valid low
    @(negedge clk);
    instr_i = itype(8, 0, 3, 16'h00AA);
    valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 flag", {31'b0, illegal_o}, 32'd0);
    instr_i = itype(2, 0, 3, 16'h0);
    @(negedge clk);
    chk("R12 flag", {31'b0, illegal_o}, 32'd0);
    chk_all("R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule